// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block is the bus-master half of a simple Ethernet transmit path. Software builds a circular ring of 16-byte descriptors in memory for each transmit queue, hands descriptors to hardware by setting their ownership bit, and then pulses the kick input for that queue. The walker starts at the queue head and visits every descriptor in the ring exactly once, ending when a next pointer leads back to the head. Each descriptor that hardware owns is consumed. Its frame bytes are fetched from memory and streamed out on a byte-wide valid/ready/last port. Its ownership bit is then cleared in memory and the queue's completion cause pulses.

Each descriptor holds four little-endian 32-bit words: word 0 is command/status, word 1 carries the byte count in its upper half, word 2 is the buffer address and word 3 is the next-descriptor address. Two queue heads come from the register block. Memory is reached through a 32-bit request/acknowledge master that handles both reads and writes. Kicks that arrive during a sweep are held and served once the sweep finishes, with the higher queue index served first.

Top module: `tx_ring_walker`

## Requirements
- R1: After reset, busy_o, tx_valid_o, mem_req_o and every bit of cause_o are low.
- R2: For a descriptor at address D, the walker reads words at D, D+4, D+8 and D+12. The ownership flag is bit 31 of word 0, the byte count is bits 31:16 of word 1, word 2 is the buffer byte address and word 3 is the next-descriptor address. A memory request holds its address and direction until it is acknowledged.
- R3: A kick on queue q starts at head_i of q, follows next pointers, and stops after the descriptor whose next pointer equals that head, so each ring member is visited once per kick.
- R4: A descriptor whose ownership bit is 0 is left unmodified in memory. It produces no frame and no cause pulse.
- R5: An owned descriptor whose byte count N lies between 1 and 2047 produces one frame of N bytes, read from the buffer address upward. The byte at address A is taken from bits 8*(A mod 4)+7 down to 8*(A mod 4) of its word. tx_last_o is high only with the final byte, and the buffer may start at any byte alignment.
- R6: An owned descriptor whose byte count is 2048 or more produces no frame, but it is still released and its cause still pulses.
- R7: An owned descriptor with byte count 0 produces no frame, but it is still released and its cause still pulses.
- R8: Release writes word 0 back to the descriptor address with bit 31 cleared and every other bit unchanged. It is the only write the walker makes to a descriptor.
- R9: Each release pulses cause_o bit (3 - q) high for exactly one cycle, where q is the queue index. No other cause bit is ever set.
- R10: busy_o is high from the first descriptor read of a sweep until the sweep ends, and memory requests and stream output occur only while busy_o is high. Kicks received during a sweep are kept and served later. When both queues are pending, queue 1 is served before queue 0.
- R11: While tx_valid_o is high and tx_ready_i is low, tx_valid_o, tx_data_o and tx_last_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| kick_i | input | NQ | One-cycle start pulse per queue |
| head_i | input | NQ*AW | Ring head address per queue, queue q in bits q*AW+AW-1:q*AW |
| busy_o | output | 1 | A sweep is in progress |
| cause_o | output | CAUSE_W | One-cycle completion pulse, bit 3-q for queue q |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | 1 for write, 0 for read |
| mem_addr_o | output | AW | Word-aligned byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Completes the pending request; read data is valid in the same cycle |
| mem_rdata_i | input | 32 | Read data |
| tx_data_o | output | 8 | Frame byte |
| tx_valid_o | output | 1 | Frame byte valid |
| tx_last_o | output | 1 | Final byte of the frame |
| tx_ready_i | input | 1 | Sink accepts the byte |

## Verification
The checker assumes that mem_ack_i is raised only while a request is pending, and that heads and descriptor addresses are word-aligned. The word-alignment property and the rule that a request stays stable until acknowledged both depend on these assumptions. The bench memory model acknowledges only requests that are pending, and every ring and head it builds uses 16-byte-aligned descriptor addresses. The ready pattern stalls the stream regularly, which exercises the hold rule, and every ring is closed back to its head so that each sweep ends.

// File: rtl/tx_walker_pkg.sv
package tx_walker_pkg;
  localparam int unsigned OWN_BIT  = 31;
  localparam int unsigned CNT_LSB  = 16;
  localparam int unsigned CNT_W    = 16;
  localparam int unsigned DESC_WDS = 4;

  typedef enum logic [2:0] {
    W_IDLE,
    W_RDESC,
    W_EVAL,
    W_SEND,
    W_WBACK,
    W_STEP
  } walk_st_e;
endpackage

// File: rtl/tx_kick_arb.sv
module tx_kick_arb #(
  parameter int NQ = 2,
  parameter int QW = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NQ-1:0] kick_i,
  input  logic          take_i,
  output logic          pend_o,
  output logic [QW-1:0] idx_o
);
  logic [NQ-1:0] pend_q;
  logic [NQ-1:0] clr;

  // highest index wins
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NQ; i++) begin
      if (pend_q[i]) idx_o = QW'(i);
    end
  end

  assign pend_o = |pend_q;
  assign clr    = take_i ? (NQ'(1) << idx_o) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr) | kick_i;
  end
endmodule

// File: rtl/tx_byte_lane.sv
module tx_byte_lane #(
  parameter int AW = 32,
  parameter int LW = 16,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  input  logic [LW-1:0] len_i,
  input  logic          word_vld_i,
  input  logic [DW-1:0] word_i,
  input  logic          ready_i,
  output logic          need_o,
  output logic [AW-1:0] waddr_o,
  output logic [7:0]    data_o,
  output logic          valid_o,
  output logic          last_o,
  output logic          active_o
);
  localparam int LANES = DW / 8;
  localparam int LSW   = $clog2(LANES);

  logic [AW-1:0]  ptr_q;
  logic [LW-1:0]  left_q;
  logic [DW-1:0]  word_q;
  logic           have_q;
  logic           act_q;
  logic [LSW-1:0] lane;
  logic           fire;

  assign lane     = ptr_q[LSW-1:0];
  assign need_o   = act_q && !have_q;
  assign waddr_o  = {ptr_q[AW-1:LSW], {LSW{1'b0}}};
  assign valid_o  = act_q && have_q;
  assign data_o   = word_q[8*lane +: 8];
  assign last_o   = valid_o && (left_q == LW'(1));
  assign active_o = act_q;
  assign fire     = valid_o && ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      left_q <= '0;
      word_q <= '0;
      have_q <= 1'b0;
      act_q  <= 1'b0;
    end else if (start_i) begin
      ptr_q  <= addr_i;
      left_q <= len_i;
      have_q <= 1'b0;
      act_q  <= (len_i != '0);
    end else begin
      if (word_vld_i && need_o) begin
        word_q <= word_i;
        have_q <= 1'b1;
      end
      if (fire) begin
        ptr_q  <= ptr_q + AW'(1);
        left_q <= left_q - LW'(1);
        if (left_q == LW'(1)) act_q <= 1'b0;
        if (lane == LSW'(LANES - 1)) have_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tx_ring_walker.sv
module tx_ring_walker
  import tx_walker_pkg::*;
#(
  parameter int NQ        = 2,
  parameter int AW        = 32,
  parameter int MAX_LEN   = 2048,
  parameter int CAUSE_W   = 4,
  parameter int CAUSE_TOP = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NQ-1:0]    kick_i,
  input  logic [NQ*AW-1:0] head_i,
  output logic             busy_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [31:0]      mem_wdata_o,
  input  logic             mem_ack_i,
  input  logic [31:0]      mem_rdata_i,
  output logic [7:0]       tx_data_o,
  output logic             tx_valid_o,
  output logic             tx_last_o,
  input  logic             tx_ready_i
);
  localparam int DW  = 32;
  localparam int QW  = (NQ > 1) ? $clog2(NQ) : 1;
  localparam int LW  = CNT_W;
  localparam int WIW = $clog2(DESC_WDS);

  walk_st_e     st_q;
  logic [QW-1:0] q_q;
  logic [AW-1:0] head_q, desc_q, buf_q, nxt_q;
  logic [WIW-1:0] widx_q;
  logic [DW-1:0] w0_q;
  logic [LW-1:0] len_q;
  logic [CAUSE_W-1:0] cause_q;

  logic          pend, take;
  logic [QW-1:0] arb_idx;
  logic          own, send_ok, lane_start;
  logic          need, lane_act;
  logic [AW-1:0] lane_waddr;
  logic          ack_rd, ack_wb;

  tx_kick_arb #(.NQ(NQ), .QW(QW)) u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .kick_i (kick_i),
    .take_i (take),
    .pend_o (pend),
    .idx_o  (arb_idx)
  );

  assign take       = (st_q == W_IDLE) && pend;
  assign own        = w0_q[OWN_BIT];
  assign send_ok    = (len_q != '0) && (32'(len_q) < 32'(MAX_LEN));
  assign lane_start = (st_q == W_EVAL) && own && send_ok;

  tx_byte_lane #(.AW(AW), .LW(LW), .DW(DW)) u_lane (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (lane_start),
    .addr_i     (buf_q),
    .len_i      (len_q),
    .word_vld_i ((st_q == W_SEND) && mem_ack_i),
    .word_i     (mem_rdata_i),
    .ready_i    (tx_ready_i),
    .need_o     (need),
    .waddr_o    (lane_waddr),
    .data_o     (tx_data_o),
    .valid_o    (tx_valid_o),
    .last_o     (tx_last_o),
    .active_o   (lane_act)
  );

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = desc_q;
    mem_wdata_o = w0_q & ~(DW'(1) << OWN_BIT);
    unique case (st_q)
      W_RDESC: begin
        mem_req_o  = 1'b1;
        mem_addr_o = desc_q + AW'({widx_q, 2'b00});
      end
      W_SEND: begin
        mem_req_o  = need;
        mem_addr_o = lane_waddr;
      end
      W_WBACK: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
      end
      default: ;
    endcase
  end

  assign ack_rd  = (st_q == W_RDESC) && mem_ack_i;
  assign ack_wb  = (st_q == W_WBACK) && mem_ack_i;
  assign busy_o  = (st_q != W_IDLE);
  assign cause_o = cause_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= W_IDLE;
      q_q     <= '0;
      head_q  <= '0;
      desc_q  <= '0;
      buf_q   <= '0;
      nxt_q   <= '0;
      widx_q  <= '0;
      w0_q    <= '0;
      len_q   <= '0;
      cause_q <= '0;
    end else begin
      cause_q <= '0;
      unique case (st_q)
        W_IDLE: if (pend) begin
          q_q    <= arb_idx;
          head_q <= head_i[arb_idx*AW +: AW];
          desc_q <= head_i[arb_idx*AW +: AW];
          widx_q <= '0;
          st_q   <= W_RDESC;
        end
        W_RDESC: if (ack_rd) begin
          unique case (widx_q)
            2'd0: w0_q  <= mem_rdata_i;
            2'd1: len_q <= mem_rdata_i[CNT_LSB +: CNT_W];
            2'd2: buf_q <= mem_rdata_i[AW-1:0];
            default: nxt_q <= mem_rdata_i[AW-1:0];
          endcase
          widx_q <= widx_q + WIW'(1);
          if (widx_q == WIW'(DESC_WDS - 1)) st_q <= W_EVAL;
        end
        W_EVAL: begin
          if (!own)         st_q <= W_STEP;
          else if (send_ok) st_q <= W_SEND;
          else              st_q <= W_WBACK;
        end
        W_SEND: if (!lane_act) st_q <= W_WBACK;
        W_WBACK: if (ack_wb) begin
          cause_q <= CAUSE_W'(1) << (CAUSE_TOP - int'(q_q));
          st_q    <= W_STEP;
        end
        W_STEP: begin
          if (nxt_q == head_q) st_q <= W_IDLE;
          else begin
            desc_q <= nxt_q;
            widx_q <= '0;
            st_q   <= W_RDESC;
          end
        end
        default: st_q <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tx_ring_walker_chk.sv
module tx_ring_walker_chk #(
  parameter int AW      = 32,
  parameter int CAUSE_W = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               busy_o,
  input logic [CAUSE_W-1:0] cause_o,
  input logic               mem_req_o,
  input logic               mem_we_o,
  input logic [AW-1:0]      mem_addr_o,
  input logic [31:0]        mem_wdata_o,
  input logic               mem_ack_i,
  input logic [7:0]         tx_data_o,
  input logic               tx_valid_o,
  input logic               tx_last_o,
  input logic               tx_ready_i
);
  a_r10_quiet_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_req_o && !tx_valid_o));

  a_r9_cause_needs_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_o != '0) |-> busy_o);

  a_r9_cause_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cause_o));

  a_r2_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  a_r2_word_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[1:0] == 2'b00));

  a_r8_release_clears_own: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> !mem_wdata_o[31]);

  a_r5_last_with_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_last_o |-> tx_valid_o);

  a_r11_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=>
      (tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o)));
endmodule

bind tx_ring_walker tx_ring_walker_chk #(.AW(AW), .CAUSE_W(CAUSE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_o      (busy_o),
  .cause_o     (cause_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ack_i   (mem_ack_i),
  .tx_data_o   (tx_data_o),
  .tx_valid_o  (tx_valid_o),
  .tx_last_o   (tx_last_o),
  .tx_ready_i  (tx_ready_i)
);

// File: tb/tx_ring_walker_bench.sv
module tx_ring_walker_bench;
  localparam int MEM_WORDS = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  kick = '0;
  logic [31:0] head0 = '0, head1 = '0;
  logic        busy;
  logic [3:0]  cause;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [7:0]  tx_data;
  logic        tx_valid, tx_last, tx_ready;

  logic [31:0] mem [0:MEM_WORDS-1];
  int          wr_cnt, c3, c2, cyc, rdy_cnt;
  int          n_chk, n_fail;
  int          ord[$];
  logic [7:0]  got_bytes[$];
  int          got_lens[$];
  int          cur_len;
  int          exp_buf[$], exp_len[$];

  always #2 clk = ~clk;

  tx_ring_walker u_tx_ring_walker (
    .clk_i(clk), .rst_ni(rst_n), .kick_i(kick), .head_i({head1, head0}),
    .busy_o(busy), .cause_o(cause),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .tx_data_o(tx_data), .tx_valid_o(tx_valid), .tx_last_o(tx_last),
    .tx_ready_i(tx_ready)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 29 + (a >> 7) + 11) & 255);
  endfunction

  // memory model: ack one cycle after a pending request
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        if (mem_we) begin
          mem[mem_addr[13:2]] <= mem_wdata;
          wr_cnt <= wr_cnt + 1;
        end else begin
          mem_rdata <= mem[mem_addr[13:2]];
        end
      end
    end
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_cnt  <= 0;
      tx_ready <= 1'b0;
    end else begin
      rdy_cnt  <= rdy_cnt + 1;
      tx_ready <= (rdy_cnt % 5) != 3;
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (tx_valid && tx_ready) begin
      got_bytes.push_back(tx_data);
      if (tx_last) begin
        got_lens.push_back(cur_len + 1);
        cur_len = 0;
      end else begin
        cur_len = cur_len + 1;
      end
    end
    if (cause[3]) begin c3++; ord.push_back(3); end
    if (cause[2]) begin c2++; ord.push_back(2); end
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_desc(input int a, input logic [31:0] w0, input int len,
                          input int bufa, input int nxt);
    mem[a >> 2]       = w0;
    mem[(a >> 2) + 1] = {len[15:0], 16'h5A5A};
    mem[(a >> 2) + 2] = bufa;
    mem[(a >> 2) + 3] = nxt;
  endtask

  task automatic clear_counts();
    c3 = 0; c2 = 0; wr_cnt = 0;
    ord.delete();
  endtask

  task automatic kick_q(input logic [1:0] k);
    @(negedge clk); kick = k;
    @(negedge clk); kick = '0;
  endtask

  task automatic wait_quiet();
    int low;
    low = 0;
    repeat (3) @(negedge clk);
    while (low < 4) begin
      @(negedge clk);
      if (!busy) low++; else low = 0;
    end
  endtask

  task automatic expect_frame(input int bufa, input int len);
    exp_buf.push_back(bufa);
    exp_len.push_back(len);
  endtask

  task automatic check_frames(input string req);
    while (exp_len.size() > 0) begin
      int eb, el, gl, bad;
      eb = exp_buf.pop_front();
      el = exp_len.pop_front();
      bad = 0;
      if (got_lens.size() == 0) begin
        chk(1'b0, req, 0, el);
      end else begin
        gl = got_lens.pop_front();
        for (int i = 0; i < gl; i++) begin
          logic [7:0] b;
          b = got_bytes.pop_front();
          if (i < el && b != pat(eb + i)) bad++;
        end
        chk(gl == el && bad == 0, req, gl * 65536 + bad, el * 65536);
      end
    end
    chk(got_lens.size() == 0, {req, " no extra frame"}, got_lens.size(), 0);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; cyc = 0; cur_len = 0; wr_cnt = 0;
    for (int w = 0; w < MEM_WORDS; w++) mem[w] = '0;
    for (int a = 'h1000; a < 'h4000; a += 4)
      mem[a >> 2] = {pat(a + 3), pat(a + 2), pat(a + 1), pat(a)};
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy, "R1 busy", busy, 0);
    chk(!tx_valid, "R1 valid", tx_valid, 0);
    chk(!mem_req, "R1 req", mem_req, 0);
    chk(cause == 0, "R1 cause", cause, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // queue 0 mixed ring, head in the middle (R3, R4, R5, R6, R7, R8)
    put_desc('h100, 32'h8000_0C3C, 5,    'h1000, 'h110);
    put_desc('h110, 32'h0000_00A5, 4,    'h1100, 'h120);
    put_desc('h120, 32'h8000_0011, 2048, 'h1200, 'h130);
    put_desc('h130, 32'h8001_0002, 7,    'h1301, 'h140);
    put_desc('h140, 32'h8000_0003, 0,    'h1400, 'h100);
    head0 = 'h120;
    clear_counts();
    kick_q(2'b01);
    wait_quiet();
    expect_frame('h1301, 7);
    expect_frame('h1000, 5);
    check_frames("R5 R3 mixed ring frames");
    chk(c3 == 4, "R9 R6 R7 queue0 releases", c3, 4);
    chk(c2 == 0, "R9 no queue1 cause", c2, 0);
    chk(wr_cnt == 4, "R8 write count", wr_cnt, 4);
    chk(mem['h100 >> 2] == 32'h0000_0C3C, "R8 own cleared rest kept", mem['h100 >> 2], 32'h0000_0C3C);
    chk(mem['h120 >> 2] == 32'h0000_0011, "R6 oversize released", mem['h120 >> 2], 32'h0000_0011);
    chk(mem['h140 >> 2] == 32'h0000_0003, "R7 zero length released", mem['h140 >> 2], 32'h0000_0003);
    chk(mem['h110 >> 2] == 32'h0000_00A5, "R4 unowned untouched", mem['h110 >> 2], 32'h0000_00A5);

    // same ring again: nothing owned (R4)
    clear_counts();
    kick_q(2'b01);
    wait_quiet();
    check_frames("R4 empty sweep");
    chk(c3 == 0 && wr_cnt == 0, "R4 no release on empty sweep", c3 + wr_cnt, 0);

    // queue 1 ring with long and 1-byte frames (R5, R9)
    put_desc('h200, 32'h8000_0000, 1,    'h2003, 'h210);
    put_desc('h210, 32'h8000_0000, 2047, 'h2100, 'h220);
    put_desc('h220, 32'h8000_0000, 4,    'h2A02, 'h200);
    head1 = 'h200;
    clear_counts();
    kick_q(2'b10);
    wait_quiet();
    expect_frame('h2003, 1);
    expect_frame('h2100, 2047);
    expect_frame('h2A02, 4);
    check_frames("R5 queue1 frames");
    chk(c2 == 3 && c3 == 0, "R9 queue1 cause bit 2", c2 * 16 + c3, 3 * 16);

    // simultaneous kicks: queue 1 first (R10)
    put_desc('h300, 32'h8000_0000, 3, 'h3000, 'h310);
    put_desc('h310, 32'h8000_0000, 3, 'h3010, 'h300);
    put_desc('h380, 32'h8000_0000, 2, 'h3080, 'h390);
    put_desc('h390, 32'h8000_0000, 2, 'h3090, 'h380);
    head0 = 'h300; head1 = 'h380;
    clear_counts();
    kick_q(2'b11);
    wait_quiet();
    expect_frame('h3080, 2); expect_frame('h3090, 2);
    expect_frame('h3000, 3); expect_frame('h3010, 3);
    check_frames("R10 priority frames");
    chk(ord.size() == 4 && ord[0] == 2 && ord[3] == 3, "R10 queue1 served first",
        ord.size() > 0 ? ord[0] : 0, 2);

    // kick during a sweep is kept (R10)
    put_desc('h300, 32'h8000_0000, 3, 'h3000, 'h310);
    put_desc('h310, 32'h8000_0000, 3, 'h3010, 'h300);
    put_desc('h380, 32'h8000_0000, 2, 'h3080, 'h390);
    put_desc('h390, 32'h8000_0000, 2, 'h3090, 'h380);
    clear_counts();
    kick_q(2'b01);
    repeat (4) @(negedge clk);
    chk(busy, "R10 busy during sweep", busy, 1);
    kick_q(2'b10);
    wait_quiet();
    expect_frame('h3000, 3); expect_frame('h3010, 3);
    expect_frame('h3080, 2); expect_frame('h3090, 2);
    check_frames("R10 latched kick frames");
    chk(ord.size() == 4 && ord[0] == 3 && ord[3] == 2, "R10 latched kick order",
        ord.size() > 0 ? ord[0] : 0, 3);

    // sweep of lengths 1..16 and all four byte alignments (R5, R8)
    for (int i = 0; i < 16; i++)
      put_desc('h400 + 16 * i, 32'h8000_0000 | i, i + 1, 'h1800 + 32 * i + (i % 4),
               (i == 15) ? 'h400 : 'h400 + 16 * (i + 1));
    head0 = 'h400;
    clear_counts();
    kick_q(2'b01);
    wait_quiet();
    for (int i = 0; i < 16; i++) expect_frame('h1800 + 32 * i + (i % 4), i + 1);
    check_frames("R5 length and alignment sweep");
    chk(c3 == 16, "R9 sweep releases", c3, 16);
    for (int i = 0; i < 16; i++)
      chk(mem[('h400 + 16 * i) >> 2] == i, "R8 sweep word0", mem[('h400 + 16 * i) >> 2], i);

    finish_run();
  end
endmodule